// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Fault Shutdown

The block is a 12-bit PWM timer that drives three channels, A, B and C. Each channel has a main output and a complementary output. One counter, shared by all channels, runs over a programmable period. Each channel compares the counter with its own duty value. A per-pair dead-time stage holds both outputs of a pair inactive for a programmable number of clock cycles after every edge of the raw waveform, so the two power switches of a leg are never on together.

Software reaches the block over a byte-wide bus with address, data and write strobe. Period and duty values are double-buffered, so a value written in the middle of a cycle only takes effect at the next period boundary. The configuration registers are guarded by a write lock that must hold the value 0x55. Two sticky flags report the period wrap and the channel A duty match, and each drives an interrupt line. A fault input kills all outputs through a path that does not wait for the clock. The fault is also latched, so the outputs stay off until software clears the latch.

Register map (4-bit address): 0x0 lock; 0x1 enable (bit7 run, bit6 fault detect enable, bits2:0 main output enables A/B/C, bits5:3 complementary output enables A/B/C); 0x2 control (bit0 main polarity, bit1 complementary polarity); 0x3 dead time; 0x4/0x5 period low byte and high nibble; 0x6/0x7, 0x8/0x9 and 0xA/0xB duty for A, B and C (low byte, then high nibble); 0xC status (bit0 wrap flag, bit1 duty flag, bit2 fault latch; writing 1 clears a bit).

Top module: `cpwm_top`

## Requirements
- R1: After reset, every register reads 0, all six outputs are 0, drv_en_o is 0 and both interrupt lines are low.
- R2: Writes to addresses 0x1 through 0xB take effect only while the lock register (address 0x0, always writable) holds 0x55. Otherwise they are ignored and the register reads back its old value.
- R3: With period P and duty D, the counter runs from 0 to P-1. The raw waveform is active while the counter is below D, so D=0 gives a constantly inactive waveform and D>=P gives a constantly active one.
- R4: After each raw edge, both outputs of a pair stay inactive for DT clock cycles. In steady state, with D>DT and P-D>DT, the main output is active for D-DT cycles per period and the complementary output for P-D-DT cycles.
- R5: The main and complementary outputs of a pair are never active at the same time.
- R6: Period and duty writes go to shadow registers. The working values load from the shadows only at a period wrap, or at any time while the timer is stopped.
- R7: Status bit0 sets on every period wrap. Status bit1 sets when the counter equals the channel A duty, which happens once per period when that duty is below P. Both bits clear when 1 is written to them, and irq_ovf_o and irq_duty_o show them.
- R8: Control bit0 inverts the three main outputs and bit1 inverts the three complementary outputs. The inactive level of an output equals its polarity bit.
- R9: An output whose enable bit is 0 stays at its inactive level, and its drv_en_o bit (same position as the enable bit) is 0.
- R10: Clearing the run bit stops the counter, drives all outputs to their inactive levels and clears drv_en_o.
- R11: While fault detect is enabled and fault_i is high, all outputs are at their inactive levels without waiting for a clock edge.
- R12: A detected fault sets status bit2. While that bit is set, the outputs stay inactive, and writing 1 to it clears it only while fault_i is low. With fault detect disabled, fault_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| fault_i | input | 1 | Fault input, active high |
| out_p_o | output | 3 | Main outputs for channels A, B, C |
| out_n_o | output | 3 | Complementary outputs for channels A, B, C |
| drv_en_o | output | 6 | Pin drive enables (bits 2:0 main, bits 5:3 complementary) |
| irq_ovf_o | output | 1 | Period-wrap interrupt |
| irq_duty_o | output | 1 | Duty-match interrupt |

## Verification
A wrong working period or duty shows up within one period: the count of active cycles in a window of P cycles on each output no longer equals D-DT or P-D-DT. A shadow that loads too early shows up in the same period as the write, as an output that changes before the next wrap. A dead-time counter that is off by one changes each count by exactly one. A fault latch that clears by itself shows up as activity on the outputs within the first period after fault_i drops, while it should stay quiet until software writes the clear.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W     = 12;
  localparam int N_CH      = 3;
  localparam int DT_W      = 8;
  localparam int ADDR_W    = 4;
  localparam logic [7:0] UNLOCK_KEY = 8'h55;
  localparam int A_LOCK    = 0;
  localparam int A_EN      = 1;
  localparam int A_CTRL    = 2;
  localparam int A_DT      = 3;
  localparam int A_PER_L   = 4;
  localparam int A_PER_H   = 5;
  localparam int A_DUTY0   = 6;
  // status follows the duty pairs
  localparam int A_STAT    = A_DUTY0 + 2 * N_CH;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NCH = N_CH,
  parameter int DTW = DT_W,
  parameter int AW  = ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic [7:0]              wdata_i,
  input  logic                    we_i,
  output logic [7:0]              rdata_o,
  input  logic                    fault_i,
  input  logic                    wrap_i,
  input  logic                    dmatch_i,
  output logic                    run_o,
  output logic                    fault_en_o,
  output logic [2*NCH-1:0]        oe_o,
  output logic                    pol_p_o,
  output logic                    pol_n_o,
  output logic [DTW-1:0]          dt_o,
  output logic [CW-1:0]           per_sh_o,
  output logic [NCH-1:0][CW-1:0]  duty_sh_o,
  output logic                    ovf_flag_o,
  output logic                    duty_flag_o,
  output logic                    fault_lat_o
);
  localparam int HW = CW - 8;

  logic [7:0]             lock_q;
  logic [7:0]             en_q;
  logic [1:0]             ctrl_q;
  logic [DTW-1:0]         dt_q;
  logic [CW-1:0]          per_q;
  logic [NCH-1:0][CW-1:0] duty_q;
  logic                   ovf_q, dfl_q, flt_q;
  logic                   unlocked, cfg_we, stat_we;

  assign unlocked = (lock_q == UNLOCK_KEY);
  assign cfg_we   = we_i && unlocked && (addr_i >= AW'(A_EN)) && (addr_i < AW'(A_STAT));
  assign stat_we  = we_i && (addr_i == AW'(A_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      en_q   <= '0;
      ctrl_q <= '0;
      dt_q   <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      if (we_i && addr_i == AW'(A_LOCK)) lock_q <= wdata_i;
      if (cfg_we) begin
        if (addr_i == AW'(A_EN))    en_q   <= wdata_i;
        if (addr_i == AW'(A_CTRL))  ctrl_q <= wdata_i[1:0];
        if (addr_i == AW'(A_DT))    dt_q   <= wdata_i[DTW-1:0];
        if (addr_i == AW'(A_PER_L)) per_q[7:0]    <= wdata_i;
        if (addr_i == AW'(A_PER_H)) per_q[CW-1:8] <= wdata_i[HW-1:0];
        for (int c = 0; c < NCH; c++) begin
          if (addr_i == AW'(A_DUTY0 + 2*c))     duty_q[c][7:0]    <= wdata_i;
          if (addr_i == AW'(A_DUTY0 + 2*c + 1)) duty_q[c][CW-1:8] <= wdata_i[HW-1:0];
        end
      end
    end
  end

  // sticky flags: set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      dfl_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      if (wrap_i)                       ovf_q <= 1'b1;
      else if (stat_we && wdata_i[0])   ovf_q <= 1'b0;
      if (dmatch_i)                     dfl_q <= 1'b1;
      else if (stat_we && wdata_i[1])   dfl_q <= 1'b0;
      if (en_q[6] && fault_i)           flt_q <= 1'b1;
      else if (stat_we && wdata_i[2])   flt_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_LOCK))  rdata_o = lock_q;
    if (addr_i == AW'(A_EN))    rdata_o = en_q;
    if (addr_i == AW'(A_CTRL))  rdata_o = 8'(ctrl_q);
    if (addr_i == AW'(A_DT))    rdata_o = 8'(dt_q);
    if (addr_i == AW'(A_PER_L)) rdata_o = per_q[7:0];
    if (addr_i == AW'(A_PER_H)) rdata_o = 8'(per_q[CW-1:8]);
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(A_DUTY0 + 2*c))     rdata_o = duty_q[c][7:0];
      if (addr_i == AW'(A_DUTY0 + 2*c + 1)) rdata_o = 8'(duty_q[c][CW-1:8]);
    end
    if (addr_i == AW'(A_STAT))  rdata_o = {5'b0, flt_q, dfl_q, ovf_q};
  end

  assign run_o       = en_q[7];
  assign fault_en_o  = en_q[6];
  assign oe_o        = en_q[2*NCH-1:0];
  assign pol_p_o     = ctrl_q[0];
  assign pol_n_o     = ctrl_q[1];
  assign dt_o        = dt_q;
  assign per_sh_o    = per_q;
  assign duty_sh_o   = duty_q;
  assign ovf_flag_o  = ovf_q;
  assign duty_flag_o = dfl_q;
  assign fault_lat_o = flt_q;

  p_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked && addr_i == AW'(A_PER_L)) |=> $stable(per_q));

  p_fault_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q && !(stat_we && wdata_i[2])) |=> flt_q);

  p_fault_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[6] && fault_i) |=> flt_q);
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NCH = N_CH
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [CW-1:0]          per_sh_i,
  input  logic [NCH-1:0][CW-1:0] duty_sh_i,
  output logic [NCH-1:0]         raw_o,
  output logic                   wrap_o,
  output logic                   dmatch_o
);
  logic [CW-1:0]          cnt_q, per_q;
  logic [NCH-1:0][CW-1:0] duty_q;
  logic                   last;

  assign last = (per_q == '0) || (cnt_q >= per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (!run_i || last) begin
      cnt_q  <= '0;
      per_q  <= per_sh_i;
      duty_q <= duty_sh_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign raw_o[c] = run_i && (duty_q[c] > cnt_q);
  end

  assign wrap_o   = run_i && last;
  assign dmatch_o = run_i && (cnt_q == duty_q[0]);

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && per_q != '0) |-> (cnt_q < per_q));

  p_hold_act_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !last) |=> ($stable(per_q) && $stable(duty_q)));
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_pkg::*;
#(
  parameter int DTW = DT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           raw_i,
  input  logic [DTW-1:0] dt_i,
  output logic           act_p_o,
  output logic           act_n_o
);
  logic           lvl_q;
  logic [DTW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else if (!run_i) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else if (raw_i != lvl_q) begin
      lvl_q <= raw_i;
      gap_q <= dt_i;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign act_p_o = run_i &&  lvl_q && (gap_q == '0);
  assign act_n_o = run_i && !lvl_q && (gap_q == '0);

  // a turn-on after a non-zero gap must follow a cycle where the partner was off
  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(act_p_o) && $past(dt_i) != '0) |-> $past(!act_n_o));
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int NCH = N_CH,
  parameter int DTW = DT_W,
  parameter int AW  = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             we_i,
  output logic [7:0]       rdata_o,
  input  logic             fault_i,
  output logic [NCH-1:0]   out_p_o,
  output logic [NCH-1:0]   out_n_o,
  output logic [2*NCH-1:0] drv_en_o,
  output logic             irq_ovf_o,
  output logic             irq_duty_o
);
  logic                   run, fault_en, pol_p, pol_n, fault_lat, wrap, dmatch;
  logic [2*NCH-1:0]       oe;
  logic [DTW-1:0]         dt;
  logic [CW-1:0]          per_sh;
  logic [NCH-1:0][CW-1:0] duty_sh;
  logic [NCH-1:0]         raw, act_p, act_n, drv_p, drv_n;
  logic                   kill;

  cpwm_regs #(.CW(CW), .NCH(NCH), .DTW(DTW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o, .fault_i,
    .wrap_i(wrap), .dmatch_i(dmatch),
    .run_o(run), .fault_en_o(fault_en), .oe_o(oe), .pol_p_o(pol_p), .pol_n_o(pol_n),
    .dt_o(dt), .per_sh_o(per_sh), .duty_sh_o(duty_sh),
    .ovf_flag_o(irq_ovf_o), .duty_flag_o(irq_duty_o), .fault_lat_o(fault_lat)
  );

  cpwm_timer #(.CW(CW), .NCH(NCH)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .per_sh_i(per_sh), .duty_sh_i(duty_sh),
    .raw_o(raw), .wrap_o(wrap), .dmatch_o(dmatch)
  );

  // asynchronous kill: no register between fault_i and the pins
  assign kill = fault_lat || (fault_en && fault_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cpwm_deadtime #(.DTW(DTW)) u_dt (
      .clk_i, .rst_ni, .run_i(run), .raw_i(raw[c]), .dt_i(dt),
      .act_p_o(act_p[c]), .act_n_o(act_n[c])
    );
    assign drv_p[c] = run && oe[c]     && !kill && act_p[c];
    assign drv_n[c] = run && oe[NCH+c] && !kill && act_n[c];

    p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((out_p_o[c] != pol_p) && (out_n_o[c] != pol_n)));
  end

  assign out_p_o  = drv_p ^ {NCH{pol_p}};
  assign out_n_o  = drv_n ^ {NCH{pol_n}};
  assign drv_en_o = oe & {2*NCH{run}};

  p_fault_kill_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_en && fault_i) |-> (out_p_o == {NCH{pol_p}} && out_n_o == {NCH{pol_n}}));

  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (drv_en_o == '0 && out_p_o == {NCH{pol_p}}));
endmodule

// File: tb/sim_cpwm_top.sv
module sim_cpwm_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       fault_i = 1'b0;
  logic [7:0] rdata_o;
  logic [2:0] out_p_o, out_n_o;
  logic [5:0] drv_en_o;
  logic       irq_ovf_o, irq_duty_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  cpwm_top u0 (.*);

  always #5 clk_i = ~clk_i;

  // {P, D, DT, main active cycles, comp active cycles}
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{10,  4, 2,  2,  4},
    '{16,  8, 0,  8,  8},
    '{20,  0, 3,  0, 20},
    '{12, 15, 2, 12,  0},
    '{ 8,  3, 1,  2,  4},
    '{30, 10, 5,  5, 15}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    addr_i = 4'(a); wdata_i = 8'(d); we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk_i);
    addr_i = 4'(a);
    #1 v = int'(rdata_o);
  endtask

  task automatic cfg(int p, int d, int dt, int ctrl, int en);
    wr(0, 8'h55);
    wr(1, 0);
    wr(2, ctrl);
    wr(3, dt);
    wr(4, p & 8'hFF);
    wr(5, p >> 8);
    for (int c = 0; c < 3; c++) begin
      wr(6 + 2*c, d & 8'hFF);
      wr(7 + 2*c, d >> 8);
    end
    wr(1, en);
    repeat (3*p + 10) @(negedge clk_i);
  endtask

  task automatic measure(int n, int ch, output int hp, output int hn);
    hp = 0; hn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      hp += int'(out_p_o[ch]);
      hn += int'(out_n_o[ch]);
    end
  endtask

  task automatic wait_ovf(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk_i);
      if (irq_ovf_o) seen = 1'b1;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, hp, hn;
    bit seen;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 out_p", int'(out_p_o), 0);
    check("R1 out_n", int'(out_n_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 drv_en", int'(drv_en_o), 0);
    check("R1 irq", int'({irq_ovf_o, irq_duty_o}), 0);
    rd(0, v);  check("R1 lock", v, 0);
    rd(12, v); check("R1 status", v, 0);

    // R2 lock guard
    wr(4, 8'h33);
    rd(4, v); check("R2 locked write ignored", v, 0);
    wr(0, 8'h55);
    rd(0, v); check("R2 lock readback", v, 8'h55);
    wr(4, 8'h33);
    rd(4, v); check("R2 unlocked write", v, 8'h33);
    wr(0, 8'h54);
    wr(2, 8'h03);
    rd(2, v); check("R2 wrong key ignored", v, 0);

    // R3 R4 vector table: active cycles over one period window
    for (int k = 0; k < NV; k++) begin
      cfg(VEC[k][0], VEC[k][1], VEC[k][2], 0, 8'hBF);
      measure(VEC[k][0], 0, hp, hn);
      check("R4 main A active cycles", hp, VEC[k][3]);
      check("R3 comp A active cycles", hn, VEC[k][4]);
      measure(VEC[k][0], 2, hp, hn);
      check("R4 main C active cycles", hp, VEC[k][3]);
    end

    // R8 polarity
    cfg(10, 4, 2, 3, 8'hBF);
    measure(10, 0, hp, hn);
    check("R8 inverted main", hp, 8);
    check("R8 inverted comp", hn, 6);

    // R9 disable main A only
    cfg(10, 4, 2, 0, 8'hBE);
    measure(10, 0, hp, hn);
    check("R9 disabled main A", hp, 0);
    check("R9 comp A still runs", hn, 4);
    check("R9 drv_en", int'(drv_en_o), 6'b111110);
    measure(10, 1, hp, hn);
    check("R9 main B unaffected", hp, 2);

    // R6 double buffering
    cfg(100, 50, 0, 0, 8'hBF);
    wr(12, 1);
    wait_ovf(seen);
    repeat (18) @(negedge clk_i);
    wr(6, 10);
    repeat (10) @(negedge clk_i);
    check("R6 old duty kept mid-period", int'(out_p_o[0]), 1);
    wr(12, 1);
    wait_ovf(seen);
    check("R7 wrap flag seen", int'(seen), 1);
    measure(100, 0, hp, hn);
    check("R6 new duty after wrap", hp, 10);

    // R7 flags
    wait_ovf(seen);
    wr(12, 3);
    check("R7 wrap flag cleared", int'(irq_ovf_o), 0);
    seen = 1'b0;
    for (int i = 0; i < 110; i++) begin
      @(negedge clk_i);
      if (irq_duty_o) seen = 1'b1;
    end
    check("R7 duty flag set", int'(seen), 1);
    rd(12, v); check("R7 status both flags", v & 3, 3);

    // R11 R12 fault
    cfg(10, 4, 0, 0, 8'hFF);
    @(negedge clk_i);
    fault_i = 1'b1;
    #1;
    check("R11 main killed without clock", int'(out_p_o), 0);
    check("R11 comp killed without clock", int'(out_n_o), 0);
    repeat (3) @(negedge clk_i);
    wr(12, 4);
    rd(12, v); check("R12 clear refused while fault high", (v >> 2) & 1, 1);
    fault_i = 1'b0;
    measure(20, 0, hp, hn);
    check("R12 outputs stay off after fault drops", hp + hn, 0);
    wr(12, 4);
    rd(12, v); check("R12 latch cleared", (v >> 2) & 1, 0);
    repeat (12) @(negedge clk_i);
    measure(10, 0, hp, hn);
    check("R12 outputs resume", hp, 4);
    wr(1, 8'hBF);
    fault_i = 1'b1;
    measure(10, 0, hp, hn);
    check("R12 fault ignored when disabled", hp, 4);
    rd(12, v); check("R12 no latch when disabled", (v >> 2) & 1, 0);
    fault_i = 1'b0;

    // R10 run clear
    wr(1, 8'h3F);
    check("R10 drv_en off", int'(drv_en_o), 0);
    measure(20, 0, hp, hn);
    check("R10 outputs idle", hp + hn + int'(out_p_o) + int'(out_n_o), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule